// File: doc/BRIEF.md
# Trained-Subcarrier Inverse Channel Estimator and Equalizer

This block turns a frequency-domain training preamble into one-tap equalizer coefficients and then applies them to received data subcarriers. Training samples arrive one subcarrier per cycle, each tagged with its preamble repetition number (0 to 3), its subcarrier index and the known ternary training value. Only every fourth subcarrier carries training. For each such subcarrier the four repetitions are summed and scaled by a shift. The received power is formed and quantised into an address for an external reciprocal table. The coefficient is then the training sign times the conjugate of the averaged value times the returned reciprocal. No divider is used.

Only the trained coefficients are stored. When a data subcarrier is presented, its coefficient is formed at read time by shift-and-add linear interpolation between the two neighbouring trained coefficients. It is then applied with one complex multiply. The equalised value leaves with its index after a fixed pipeline delay. The reciprocal table sits outside the block so that its contents can be chosen to fit the link.

Top module: `chest_eq`

## Requirements
- R1: While rst_ni is low and after its release until data is presented, eq_valid_o is 0.
- R2: For a trained subcarrier, repetition 0 restarts its running sum and repetitions 1 to 3 add to it. On repetition 3 the average is floor(sum/4), taken as an arithmetic right shift by 2.
- R3: The training value trn_ref_i is 2-bit two's complement: 01 is +1 and 11 is -1. Codes 00 and 10 mark an unused subcarrier, whose coefficient is zero whatever the table returns.
- R4: One cycle after the repetition-3 sample of a trained subcarrier is presented, rcp_addr_o equals min(floor((avg_re² + avg_im²) / 2^PWR_SHIFT), 2^W_RA − 1). rcp_data_i is read in that same cycle.
- R5: With t the training value and r = rcp_data_i, the stored coefficient is re = sat(floor(t·avg_re·r / 2^C_SHIFT)) and im = sat(floor(−t·avg_im·r / 2^C_SHIFT)). sat clamps to the signed W_C-bit range.
- R6: Trained subcarriers are the indices k with k mod 4 = 1, and slot m = k div 4 holds index 4m+1. Training samples at any other index change nothing.
- R7: For a data index k with 1 < k < 4·(N_SC/4 − 1) + 1 and f = (k−1) mod 4 ≠ 0, the coefficient is floor(((4−f)·a + f·b)/4). Here a and b are the coefficients of slots (k−1) div 4 and its successor.
- R8: Index 0 uses a zero coefficient. Indices above the last trained index reuse the last trained coefficient.
- R9: A data sample presented in one cycle gives eq_valid_o three cycles later, with eq_idx_o equal to its index. The outputs are eq_re_o = floor((x_re·c_re − x_im·c_im)/2^Y_SHIFT) and eq_im_o = floor((x_re·c_im + x_im·c_re)/2^Y_SHIFT). In every other cycle eq_valid_o is 0.
- R10: Repeating a training round for a subcarrier replaces its coefficient with the one from the newest round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trn_valid_i | input | 1 | Training sample valid |
| trn_sym_i | input | 2 | Preamble repetition number 0..3 |
| trn_idx_i | input | $clog2(N_SC) | Training subcarrier index |
| trn_re_i | input | W_IN | Training sample real part, signed |
| trn_im_i | input | W_IN | Training sample imaginary part, signed |
| trn_ref_i | input | 2 | Known ternary training value |
| rcp_addr_o | output | W_RA | Quantised power address to reciprocal table |
| rcp_data_i | input | W_R | Unsigned reciprocal returned by the table |
| data_valid_i | input | 1 | Data sample valid |
| data_idx_i | input | $clog2(N_SC) | Data subcarrier index |
| data_re_i | input | W_IN | Data sample real part, signed |
| data_im_i | input | W_IN | Data sample imaginary part, signed |
| eq_valid_o | output | 1 | Equalised sample valid |
| eq_idx_o | output | $clog2(N_SC) | Index of the equalised sample |
| eq_re_o | output | W_IN+W_C+1−Y_SHIFT | Equalised real part, signed |
| eq_im_o | output | W_IN+W_C+1−Y_SHIFT | Equalised imaginary part, signed |

## Verification
Three results are due at fixed delays. The table address appears one cycle after a repetition-3 training sample. The coefficient can be used two cycles after that sample. The equalised output appears three cycles after its data sample. The bench stamps every expected address and output with the cycle in which it is due and samples on the falling edge of that cycle. In each cycle with no output due, it requires eq_valid_o to be 0. Data is presented only after the coefficient writes have settled, so an expected value never depends on a write that is still in flight.

// File: rtl/chest_pkg.sv
package chest_pkg;
  typedef enum logic [1:0] {SGN_ZERO, SGN_POS, SGN_NEG} sgn_e;

  function automatic sgn_e decode_ref(input logic [1:0] code);
    case (code)
      2'b01:   return SGN_POS;
      2'b11:   return SGN_NEG;
      default: return SGN_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/chest_avg.sv
module chest_avg #(
  parameter int N_SC = 64,
  parameter int W_IN = 12,
  localparam int N_TR = N_SC / 4,
  localparam int W_IDX = $clog2(N_SC),
  localparam int W_SLOT = $clog2(N_TR),
  localparam int W_ACC = W_IN + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    trn_valid_i,
  input  logic [1:0]              trn_sym_i,
  input  logic [W_IDX-1:0]        trn_idx_i,
  input  logic signed [W_IN-1:0]  trn_re_i,
  input  logic signed [W_IN-1:0]  trn_im_i,
  input  logic [1:0]              trn_ref_i,
  output logic                    avg_valid_o,
  output logic [W_SLOT-1:0]       avg_slot_o,
  output logic signed [W_IN-1:0]  avg_re_o,
  output logic signed [W_IN-1:0]  avg_im_o,
  output logic [1:0]              avg_ref_o
);
  logic signed [W_ACC-1:0] acc_re [N_TR];
  logic signed [W_ACC-1:0] acc_im [N_TR];
  logic signed [W_ACC-1:0] sum_re, sum_im;
  logic [W_SLOT-1:0] slot;
  logic hit;

  assign hit  = trn_valid_i && (trn_idx_i[1:0] == 2'b01);
  assign slot = trn_idx_i[W_IDX-1:2];

  // repetition 0 restarts the running sum
  always_comb begin
    sum_re = W_ACC'(trn_re_i);
    sum_im = W_ACC'(trn_im_i);
    if (trn_sym_i != 2'd0) begin
      sum_re = sum_re + acc_re[slot];
      sum_im = sum_im + acc_im[slot];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_TR; i++) begin
        acc_re[i] <= '0;
        acc_im[i] <= '0;
      end
      avg_valid_o <= 1'b0;
      avg_slot_o  <= '0;
      avg_re_o    <= '0;
      avg_im_o    <= '0;
      avg_ref_o   <= '0;
    end else begin
      if (hit) begin
        acc_re[slot] <= sum_re;
        acc_im[slot] <= sum_im;
      end
      avg_valid_o <= hit && (trn_sym_i == 2'd3);
      avg_slot_o  <= slot;
      avg_re_o    <= W_IN'(sum_re >>> 2);
      avg_im_o    <= W_IN'(sum_im >>> 2);
      avg_ref_o   <= trn_ref_i;
    end
  end

  p_trained_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avg_valid_o |-> ($past(trn_idx_i[1:0]) == 2'b01) && ($past(trn_sym_i) == 2'd3));
endmodule

// File: rtl/chest_coef.sv
module chest_coef import chest_pkg::*; #(
  parameter int N_SC = 64,
  parameter int W_IN = 12,
  parameter int W_C = 18,
  parameter int W_R = 18,
  parameter int W_RA = 12,
  parameter int PWR_SHIFT = 10,
  parameter int C_SHIFT = 12,
  localparam int N_TR = N_SC / 4,
  localparam int W_SLOT = $clog2(N_TR),
  localparam int W_PQ = 2 * W_IN,
  localparam int W_PR = W_IN + W_R + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   avg_valid_i,
  input  logic [W_SLOT-1:0]      avg_slot_i,
  input  logic signed [W_IN-1:0] avg_re_i,
  input  logic signed [W_IN-1:0] avg_im_i,
  input  logic [1:0]             avg_ref_i,
  output logic [W_RA-1:0]        rcp_addr_o,
  input  logic [W_R-1:0]         rcp_data_i,
  input  logic [W_SLOT-1:0]      rd_a_i,
  input  logic [W_SLOT-1:0]      rd_b_i,
  output logic signed [W_C-1:0]  a_re_o,
  output logic signed [W_C-1:0]  a_im_o,
  output logic signed [W_C-1:0]  b_re_o,
  output logic signed [W_C-1:0]  b_im_o
);
  logic signed [W_C-1:0] mem_re [N_TR];
  logic signed [W_C-1:0] mem_im [N_TR];
  logic signed [W_PQ-1:0] sq_re, sq_im;
  logic [W_PQ-1:0] pwr, pq;
  logic signed [W_IN:0] sr, si;
  logic signed [W_PR-1:0] pr_re, pr_im, sh_re, sh_im;
  logic signed [W_C-1:0] c_re, c_im;
  sgn_e sgn;

  function automatic logic signed [W_C-1:0] sat_c(input logic signed [W_PR-1:0] v);
    logic [W_PR-W_C:0] top;
    top = v[W_PR-1:W_C-1];
    if (&top || !(|top)) return v[W_C-1:0];
    return v[W_PR-1] ? {1'b1, {(W_C-1){1'b0}}} : {1'b0, {(W_C-1){1'b1}}};
  endfunction

  assign sq_re = W_PQ'(avg_re_i) * W_PQ'(avg_re_i);
  assign sq_im = W_PQ'(avg_im_i) * W_PQ'(avg_im_i);
  assign pwr   = $unsigned(sq_re) + $unsigned(sq_im);
  assign pq    = pwr >> PWR_SHIFT;
  assign rcp_addr_o = ((pq >> W_RA) != '0) ? '1 : pq[W_RA-1:0];

  assign sgn = decode_ref(avg_ref_i);

  // sign select stands in for the training multiply; conj flips im
  always_comb begin
    sr = (W_IN+1)'(avg_re_i);
    si = -(W_IN+1)'(avg_im_i);
    if (sgn == SGN_NEG) begin
      sr = -sr;
      si = -si;
    end
  end

  assign pr_re = W_PR'(sr) * W_PR'($signed({1'b0, rcp_data_i}));
  assign pr_im = W_PR'(si) * W_PR'($signed({1'b0, rcp_data_i}));
  assign sh_re = pr_re >>> C_SHIFT;
  assign sh_im = pr_im >>> C_SHIFT;
  assign c_re  = (sgn == SGN_ZERO) ? '0 : sat_c(sh_re);
  assign c_im  = (sgn == SGN_ZERO) ? '0 : sat_c(sh_im);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_TR; i++) begin
        mem_re[i] <= '0;
        mem_im[i] <= '0;
      end
    end else if (avg_valid_i) begin
      mem_re[avg_slot_i] <= c_re;
      mem_im[avg_slot_i] <= c_im;
    end
  end

  assign a_re_o = mem_re[rd_a_i];
  assign a_im_o = mem_im[rd_a_i];
  assign b_re_o = mem_re[rd_b_i];
  assign b_im_o = mem_im[rd_b_i];
endmodule

// File: rtl/chest_interp.sv
module chest_interp #(
  parameter int N_SC = 64,
  parameter int W_IN = 12,
  parameter int W_C = 18,
  localparam int N_TR = N_SC / 4,
  localparam int W_IDX = $clog2(N_SC),
  localparam int W_SLOT = $clog2(N_TR),
  localparam int W_E = W_C + 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   data_valid_i,
  input  logic [W_IDX-1:0]       data_idx_i,
  input  logic signed [W_IN-1:0] data_re_i,
  input  logic signed [W_IN-1:0] data_im_i,
  output logic [W_SLOT-1:0]      rd_a_o,
  output logic [W_SLOT-1:0]      rd_b_o,
  input  logic signed [W_C-1:0]  a_re_i,
  input  logic signed [W_C-1:0]  a_im_i,
  input  logic signed [W_C-1:0]  b_re_i,
  input  logic signed [W_C-1:0]  b_im_i,
  output logic                   iv_o,
  output logic [W_IDX-1:0]       iidx_o,
  output logic signed [W_IN-1:0] ix_re_o,
  output logic signed [W_IN-1:0] ix_im_o,
  output logic signed [W_C-1:0]  ic_re_o,
  output logic signed [W_C-1:0]  ic_im_o
);
  logic [W_IDX-1:0] idx_m1;
  logic last;
  logic s1_v, s1_dc;
  logic [1:0] s1_f;
  logic [W_IDX-1:0] s1_idx;
  logic signed [W_IN-1:0] s1_xr, s1_xi;
  logic signed [W_C-1:0] s1_ar, s1_ai, s1_br, s1_bi;
  logic signed [W_C-1:0] cr, ci;

  assign idx_m1 = data_idx_i - W_IDX'(1);
  assign rd_a_o = idx_m1[W_IDX-1:2];
  assign last   = (rd_a_o == W_SLOT'(N_TR - 1));
  assign rd_b_o = last ? rd_a_o : rd_a_o + W_SLOT'(1);

  function automatic logic signed [W_C-1:0] blend(input logic signed [W_C-1:0] a,
      input logic signed [W_C-1:0] b, input logic [1:0] f);
    logic signed [W_E-1:0] aw, bw;
    aw = W_E'(a);
    bw = W_E'(b);
    case (f)
      2'd1:    return W_C'(((aw <<< 1) + aw + bw) >>> 2);
      2'd2:    return W_C'((aw + bw) >>> 1);
      2'd3:    return W_C'(((bw <<< 1) + bw + aw) >>> 2);
      default: return a;
    endcase
  endfunction

  assign cr = s1_dc ? '0 : blend(s1_ar, s1_br, s1_f);
  assign ci = s1_dc ? '0 : blend(s1_ai, s1_bi, s1_f);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_dc <= 1'b0; s1_f <= '0; s1_idx <= '0;
      s1_xr <= '0; s1_xi <= '0;
      s1_ar <= '0; s1_ai <= '0; s1_br <= '0; s1_bi <= '0;
      iv_o <= 1'b0; iidx_o <= '0; ix_re_o <= '0; ix_im_o <= '0;
      ic_re_o <= '0; ic_im_o <= '0;
    end else begin
      s1_v   <= data_valid_i;
      s1_dc  <= (data_idx_i == '0);
      s1_f   <= last ? 2'd0 : idx_m1[1:0];
      s1_idx <= data_idx_i;
      s1_xr  <= data_re_i;
      s1_xi  <= data_im_i;
      s1_ar  <= a_re_i;
      s1_ai  <= a_im_i;
      s1_br  <= b_re_i;
      s1_bi  <= b_im_i;
      iv_o    <= s1_v;
      iidx_o  <= s1_idx;
      ix_re_o <= s1_xr;
      ix_im_o <= s1_xi;
      ic_re_o <= cr;
      ic_im_o <= ci;
    end
  end
endmodule

// File: rtl/chest_eq.sv
module chest_eq #(
  parameter int N_SC = 64,
  parameter int W_IN = 12,
  parameter int W_C = 18,
  parameter int W_R = 18,
  parameter int W_RA = 12,
  parameter int PWR_SHIFT = 10,
  parameter int C_SHIFT = 12,
  parameter int Y_SHIFT = 12,
  localparam int N_TR = N_SC / 4,
  localparam int W_IDX = $clog2(N_SC),
  localparam int W_SLOT = $clog2(N_TR),
  localparam int W_P = W_IN + W_C + 1,
  localparam int W_Y = W_P - Y_SHIFT
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   trn_valid_i,
  input  logic [1:0]             trn_sym_i,
  input  logic [W_IDX-1:0]       trn_idx_i,
  input  logic signed [W_IN-1:0] trn_re_i,
  input  logic signed [W_IN-1:0] trn_im_i,
  input  logic [1:0]             trn_ref_i,
  output logic [W_RA-1:0]        rcp_addr_o,
  input  logic [W_R-1:0]         rcp_data_i,
  input  logic                   data_valid_i,
  input  logic [W_IDX-1:0]       data_idx_i,
  input  logic signed [W_IN-1:0] data_re_i,
  input  logic signed [W_IN-1:0] data_im_i,
  output logic                   eq_valid_o,
  output logic [W_IDX-1:0]       eq_idx_o,
  output logic signed [W_Y-1:0]  eq_re_o,
  output logic signed [W_Y-1:0]  eq_im_o
);
  logic avg_valid;
  logic [W_SLOT-1:0] avg_slot, rd_a, rd_b;
  logic signed [W_IN-1:0] avg_re, avg_im;
  logic [1:0] avg_ref;
  logic signed [W_C-1:0] a_re, a_im, b_re, b_im;
  logic iv;
  logic [W_IDX-1:0] iidx;
  logic signed [W_IN-1:0] ix_re, ix_im;
  logic signed [W_C-1:0] ic_re, ic_im;
  logic signed [W_P-1:0] p_re, p_im;

  chest_avg #(.N_SC(N_SC), .W_IN(W_IN)) u_avg (
    .clk_i, .rst_ni, .trn_valid_i, .trn_sym_i, .trn_idx_i, .trn_re_i, .trn_im_i, .trn_ref_i,
    .avg_valid_o(avg_valid), .avg_slot_o(avg_slot), .avg_re_o(avg_re), .avg_im_o(avg_im),
    .avg_ref_o(avg_ref));

  chest_coef #(.N_SC(N_SC), .W_IN(W_IN), .W_C(W_C), .W_R(W_R), .W_RA(W_RA),
    .PWR_SHIFT(PWR_SHIFT), .C_SHIFT(C_SHIFT)) u_coef (
    .clk_i, .rst_ni, .avg_valid_i(avg_valid), .avg_slot_i(avg_slot), .avg_re_i(avg_re),
    .avg_im_i(avg_im), .avg_ref_i(avg_ref), .rcp_addr_o, .rcp_data_i,
    .rd_a_i(rd_a), .rd_b_i(rd_b), .a_re_o(a_re), .a_im_o(a_im), .b_re_o(b_re), .b_im_o(b_im));

  chest_interp #(.N_SC(N_SC), .W_IN(W_IN), .W_C(W_C)) u_interp (
    .clk_i, .rst_ni, .data_valid_i, .data_idx_i, .data_re_i, .data_im_i,
    .rd_a_o(rd_a), .rd_b_o(rd_b), .a_re_i(a_re), .a_im_i(a_im), .b_re_i(b_re), .b_im_i(b_im),
    .iv_o(iv), .iidx_o(iidx), .ix_re_o(ix_re), .ix_im_o(ix_im), .ic_re_o(ic_re), .ic_im_o(ic_im));

  assign p_re = W_P'(ix_re) * W_P'(ic_re) - W_P'(ix_im) * W_P'(ic_im);
  assign p_im = W_P'(ix_re) * W_P'(ic_im) + W_P'(ix_im) * W_P'(ic_re);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_valid_o <= 1'b0;
      eq_idx_o   <= '0;
      eq_re_o    <= '0;
      eq_im_o    <= '0;
    end else begin
      eq_valid_o <= iv;
      eq_idx_o   <= iidx;
      eq_re_o    <= W_Y'(p_re >>> Y_SHIFT);
      eq_im_o    <= W_Y'(p_im >>> Y_SHIFT);
    end
  end

  // edges since reset, so $past never reaches back into reset
  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (eq_valid_o == $past(data_valid_i, 3)));
  p_index_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) && eq_valid_o |-> (eq_idx_o == $past(data_idx_i, 3)));
  p_dc_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_valid_o && (eq_idx_o == '0) |-> (eq_re_o == '0) && (eq_im_o == '0));
endmodule

// File: tb/sim_chest_eq.sv
module sim_chest_eq;
  localparam int N_SC = 64;
  localparam int N_TR = N_SC / 4;
  localparam int W_IN = 12;
  localparam int W_C = 18;
  localparam int W_Y = W_IN + W_C + 1 - 12;
  localparam longint CMAX = 131071;
  localparam longint CMIN = -131072;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic trn_valid = 1'b0;
  logic [1:0] trn_sym = '0;
  logic [5:0] trn_idx = '0;
  logic signed [W_IN-1:0] trn_re = '0, trn_im = '0;
  logic [1:0] trn_ref = '0;
  logic [11:0] rcp_addr;
  logic [17:0] rcp_data;
  logic data_valid = 1'b0;
  logic [5:0] data_idx = '0;
  logic signed [W_IN-1:0] data_re = '0, data_im = '0;
  logic eq_valid;
  logic [5:0] eq_idx;
  logic signed [W_Y-1:0] eq_re, eq_im;

  chest_eq u0 (
    .clk_i(clk), .rst_ni(rst_n), .trn_valid_i(trn_valid), .trn_sym_i(trn_sym),
    .trn_idx_i(trn_idx), .trn_re_i(trn_re), .trn_im_i(trn_im), .trn_ref_i(trn_ref),
    .rcp_addr_o(rcp_addr), .rcp_data_i(rcp_data), .data_valid_i(data_valid),
    .data_idx_i(data_idx), .data_re_i(data_re), .data_im_i(data_im),
    .eq_valid_o(eq_valid), .eq_idx_o(eq_idx), .eq_re_o(eq_re), .eq_im_o(eq_im));

  bit tbl_max = 1'b0;
  function automatic int rcp_fn(int a, bit mx);
    int v;
    if (mx || a == 0) return 262143;
    v = 33554432 / a;
    return (v > 262143) ? 262143 : v;
  endfunction
  always_comb rcp_data = 18'(rcp_fn(int'(rcp_addr), tbl_max));

  int errs = 0, checks = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  int acc_re [N_TR], acc_im [N_TR];
  longint c_re [N_TR], c_im [N_TR];
  typedef struct {int due; int idx; longint re; longint im; string tag;} exp_t;
  typedef struct {int due; int addr;} adr_t;
  exp_t q[$];
  adr_t aq[$];

  function automatic longint sat(longint v);
    return (v > CMAX) ? CMAX : (v < CMIN) ? CMIN : v;
  endfunction

  task automatic coef_at(int k, output longint cr, output longint ci);
    int m, f;
    if (k == 0) begin cr = 0; ci = 0; return; end
    m = (k - 1) / 4; f = (k - 1) % 4;
    if (f == 0 || m == N_TR - 1) begin cr = c_re[m]; ci = c_im[m]; end
    else begin
      cr = (c_re[m] * (4 - f) + c_re[m+1] * f) >>> 2;
      ci = (c_im[m] * (4 - f) + c_im[m+1] * f) >>> 2;
    end
  endtask

  task automatic trn(int idx, int sym, int re, int im, int code);
    int m, ar, ai, a, t;
    longint pw;
    @(negedge clk);
    trn_valid = 1'b1; trn_sym = 2'(sym); trn_idx = 6'(idx);
    trn_re = W_IN'(re); trn_im = W_IN'(im); trn_ref = 2'(code);
    if (idx % 4 == 1) begin
      m = idx / 4;
      if (sym == 0) begin acc_re[m] = re; acc_im[m] = im; end
      else begin acc_re[m] += re; acc_im[m] += im; end
      if (sym == 3) begin
        ar = acc_re[m] >>> 2; ai = acc_im[m] >>> 2;
        pw = longint'(ar) * ar + longint'(ai) * ai;
        a = int'(pw >> 10);
        if (a > 4095) a = 4095;
        aq.push_back('{cyc + 1, a});
        t = (code == 1) ? 1 : (code == 3) ? -1 : 0;
        c_re[m] = sat((longint'(t) * ar * rcp_fn(a, tbl_max)) >>> 12);
        c_im[m] = sat((longint'(-t) * ai * rcp_fn(a, tbl_max)) >>> 12);
      end
    end
  endtask

  task automatic dat(int idx, int re, int im, string tag);
    longint cr, ci;
    @(negedge clk);
    data_valid = 1'b1; data_idx = 6'(idx); data_re = W_IN'(re); data_im = W_IN'(im);
    coef_at(idx, cr, ci);
    q.push_back('{cyc + 3, idx, (longint'(re) * cr - longint'(im) * ci) >>> 12,
                  (longint'(re) * ci + longint'(im) * cr) >>> 12, tag});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trn_valid = 1'b0; data_valid = 1'b0;
    end
  endtask

  function automatic string tag_of(int k);
    if (k == 0 || k > 4 * (N_TR - 1) + 1) return "R8";
    if (k % 4 != 1) return "R7";
    if ((k / 4) % 5 >= 3) return "R3";
    return "R5";
  endfunction

  // per-cycle comparison against the due stamps
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        check(eq_valid == 1'b1, e.tag, "valid", longint'(eq_valid), 1);
        check(int'(eq_idx) == e.idx, e.tag, "index", longint'(eq_idx), e.idx);
        check(longint'(eq_re) == e.re, e.tag, "re", longint'(eq_re), e.re);
        check(longint'(eq_im) == e.im, e.tag, "im", longint'(eq_im), e.im);
      end else begin
        check(eq_valid == 1'b0, "R9", "idle valid", longint'(eq_valid), 0);
      end
      if (aq.size() > 0 && aq[0].due == cyc) begin
        adr_t a;
        a = aq.pop_front();
        check(int'(rcp_addr) == a.addr, "R4", "table address", longint'(rcp_addr), a.addr);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < N_TR; i++) begin acc_re[i] = 0; acc_im[i] = 0; c_re[i] = 0; c_im[i] = 0; end
    repeat (3) @(negedge clk);
    check(eq_valid == 1'b0, "R1", "valid in reset", longint'(eq_valid), 0);
    rst_n = 1'b1;
    idle(3);
    check(eq_valid == 1'b0, "R1", "valid after reset", longint'(eq_valid), 0);

    // full preamble, repetition-major, with stray untrained samples (R6)
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < N_TR; m++) begin
        int code;
        code = (m % 5 == 3) ? 0 : (m % 5 == 4) ? 2 : (m % 2 == 1) ? 3 : 1;
        trn(4 * m + 1, s, 300 + 37 * m + 3 * s - 4, -200 + 23 * m + 2 * s - 3, code);
      end
      trn(2, s, -1900, 1800, 1);
      trn(6, s, 1500, -1700, 3);
    end
    idle(4);

    dat(1, 700, -300, "R2");
    dat(2, 500, 250, "R6");
    dat(6, -400, 350, "R6");
    for (int k = 0; k < N_SC; k++) dat(k, 400 - 9 * k, 150 + 5 * k, tag_of(k));
    idle(6);

    // retrain slot 0 with a new round (R10)
    for (int s = 0; s < 4; s++) trn(1, s, -800 + s, 600 - 2 * s, 3);
    idle(4);
    dat(1, 900, 100, "R10");
    dat(2, -650, 420, "R10");
    idle(6);

    // saturation corner: full-scale average with maximum reciprocal (R5)
    tbl_max = 1'b1;
    for (int s = 0; s < 4; s++) trn(9, s, -2048, -2048, 3);
    idle(4);
    tbl_max = 1'b0;
    dat(9, 1000, -1000, "R5");
    dat(10, 333, 777, "R7");
    idle(8);
    check(q.size() == 0, "R9", "outputs drained", q.size(), 0);
    finish_run();
  end
endmodule